// File: doc/BRIEF.md
# Translation Cache with Access-Right Checking

This block is a small fully associative cache of page translations. Each entry maps a virtual page number to a physical page number. The entry is tagged with an address-space identifier, so translations of different processes can stay resident together. The entry also carries read, write, execute and kernel-only permission flags and a dirty flag. A lookup is purely combinational. In the same cycle the block returns the physical page and a hit indication. It also reports whether the access breaks the entry's rights, given the access kind (load, store, fetch) and the privilege mode.

On a miss the block raises a walk request toward a page-table walker. The request stays up for as long as the requester presents the missing page, until a refill installs it. A refill goes to the lowest-numbered invalid slot. When no slot is invalid, a clock hand picks the victim. The hand moves past recently referenced entries and clears their reference bits as it goes, and it stops at the first entry whose reference bit is already clear. A flush drops every translation at once.

A store to a page whose dirty flag is clear must not complete until the page table itself is updated. The block offers this update as a valid/ready pair: `dirty_req` is the valid and `dirty_ack` is the ready. `dirty_req` stays high for as long as the store is presented and the entry is still clean. The requester may hold `dirty_ack` low for any number of cycles. The entry's dirty flag is set on the clock edge where both are high. Refills are accepted on every cycle they are presented.

Top module: `tlb_guard`

## Requirements
- R1: After reset, every lookup misses: `hit` is 0, and `walk_req` equals `req_valid`.
- R2: A lookup that matches a valid entry on both page number and address-space identifier gives `hit`=1 and the stored physical page on `xl_ppn` in the same cycle. When no fault or dirty update applies, it also gives `grant`=1.
- R3: An entry installed under one address-space identifier does not hit for the same page number under another identifier. At most one entry matches any lookup.
- R4: The access kind `req_acc` is encoded as 0 = load, 1 = store, 2 = fetch, and 3 always faults. A load needs the read flag, a store needs the write flag and a fetch needs the execute flag. A hit without the needed flag gives `fault`=1 and `grant`=0. Refill permission bits are: bit0 read, bit1 write, bit2 execute, bit3 kernel-only.
- R5: An entry marked kernel-only faults when `req_user`=1. It does not fault for the same access with `req_user`=0.
- R6: A permitted store to a clean entry gives `dirty_req`=1 and `grant`=0. After an edge with `dirty_req` and `dirty_ack` both high, the same store gives `grant`=1 and `dirty_req`=0.
- R7: A fault takes priority: while `fault`=1, both `dirty_req` and `grant` are 0.
- R8: `walk_req` stays 1 on every cycle a missing page is presented, until a refill installs it. From the cycle after the refill, the lookup hits.
- R9: A refill goes to the lowest-numbered invalid entry, so N distinct refills after a flush are all resident together.
- R10: When all entries are valid, the refill replaces the first entry at or after the clock hand whose reference bit is clear. It clears the reference bits of the entries it passes, and the hand moves to the slot after the victim. If every reference bit is set, all are cleared and the entry at the hand is replaced. A refill sets the new entry's reference bit, and a hit without a fault sets the hit entry's reference bit.
- R11: `flush` invalidates all entries, so every lookup on the next cycle misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup presented this cycle |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_asid | input | ASID_W | Address-space identifier of the requester |
| hit | output | 1 | Valid entry matched |
| fault | output | 1 | Matched entry forbids this access |
| grant | output | 1 | Access may complete |
| xl_ppn | output | PPN_W | Physical page of the matched entry |
| walk_req | output | 1 | Miss; a page-table walk is needed |
| dirty_req | output | 1 | Valid: page table must mark this page dirty |
| dirty_ack | input | 1 | Ready for the dirty update |
| refill_valid | input | 1 | Install a translation this cycle |
| refill_vpn | input | VPN_W | Virtual page of the refill |
| refill_asid | input | ASID_W | Address-space identifier of the refill |
| refill_ppn | input | PPN_W | Physical page of the refill |
| refill_perm | input | 4 | Rights: bit0 read, bit1 write, bit2 execute, bit3 kernel-only |
| refill_dirty | input | 1 | Dirty flag of the refilled page |
| flush | input | 1 | Invalidate all entries |

## Verification
Lookups are tried against an empty array, against one entry under its own identifier and under a foreign identifier, and with every access kind against entries whose rights differ. This separates tag matching from rights checking. Stores to a clean page are presented before and after the dirty handshake, and a store to a clean page that lacks write rights shows that a fault masks the dirty request. Filling the array from empty and then refilling twice, with one hit in between, separates the first-invalid placement from the clock-hand choice. It also shows whether a hit re-arms a reference bit.

// File: rtl/tlb_guard_pkg.sv
`timescale 1ns/1ps
package tlb_guard_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  typedef struct packed {
    logic vld;
    logic rd;
    logic wr;
    logic ex;
    logic kern;
    logic dirty;
    logic refb;
  } ent_flags_t;
endpackage

// File: rtl/tlb_lookup.sv
`timescale 1ns/1ps
module tlb_lookup #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]             vld,
  input  logic [N-1:0][VPN_W-1:0]  vpn_a,
  input  logic [N-1:0][ASID_W-1:0] asid_a,
  input  logic [VPN_W-1:0]         req_vpn,
  input  logic [ASID_W-1:0]        req_asid,
  output logic [N-1:0]             match_vec,
  output logic                     any_match,
  output logic [IDX_W-1:0]         hit_idx
);
  // R2/R3: page number and address-space tag must both agree
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = vld[g] && (vpn_a[g] == req_vpn) && (asid_a[g] == req_asid);
  end

  assign any_match = |match_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     refb,
  input  logic [IDX_W-1:0] hand,
  output logic [IDX_W-1:0] fill_idx,
  output logic             use_clock,
  output logic [N-1:0]     clr_mask
);
  logic             inv_found;
  logic [IDX_W-1:0] inv_idx;
  logic             ref_found;
  logic [IDX_W-1:0] vic_idx;
  logic [IDX_W-1:0] idx;

  // R9: lowest-numbered invalid slot
  always_comb begin
    inv_found = 1'b0;
    inv_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!vld[i] && !inv_found) begin
        inv_found = 1'b1;
        inv_idx   = IDX_W'(i);
      end
    end
  end

  // R10: sweep from the hand, clearing set reference bits until a clear one
  always_comb begin
    ref_found = 1'b0;
    vic_idx   = hand;
    clr_mask  = '0;
    idx       = hand;
    for (int k = 0; k < N; k++) begin
      idx = IDX_W'((int'(hand) + k) % N);
      if (!ref_found) begin
        if (!refb[idx]) begin
          ref_found = 1'b1;
          vic_idx   = idx;
        end else begin
          clr_mask[idx] = 1'b1;
        end
      end
    end
    if (!ref_found) vic_idx = hand;
  end

  assign use_clock = !inv_found;
  assign fill_idx  = inv_found ? inv_idx : vic_idx;
endmodule

// File: rtl/tlb_guard.sv
`timescale 1ns/1ps
module tlb_guard #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 16,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic [ASID_W-1:0] req_asid,
  output logic              hit,
  output logic              fault,
  output logic              grant,
  output logic [PPN_W-1:0]  xl_ppn,
  output logic              walk_req,
  output logic              dirty_req,
  input  logic              dirty_ack,
  input  logic              refill_valid,
  input  logic [VPN_W-1:0]  refill_vpn,
  input  logic [ASID_W-1:0] refill_asid,
  input  logic [PPN_W-1:0]  refill_ppn,
  input  logic [3:0]        refill_perm,
  input  logic              refill_dirty,
  input  logic              flush
);
  import tlb_guard_pkg::*;

  ent_flags_t [N-1:0]        fl_q;
  logic [N-1:0][VPN_W-1:0]   vpn_q;
  logic [N-1:0][ASID_W-1:0]  asid_q;
  logic [N-1:0][PPN_W-1:0]   ppn_q;
  logic [IDX_W-1:0]          hand_q;

  logic [N-1:0]     vld_v, ref_v, match_vec, clr_mask;
  logic             any_match, use_clock;
  logic [IDX_W-1:0] hit_idx, fill_idx;
  ent_flags_t       sel;
  acc_e             acc;
  logic             perm_bad, is_store, ok_hit;

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign vld_v[g] = fl_q[g].vld;
    assign ref_v[g] = fl_q[g].refb;
  end

  tlb_lookup #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lookup (
    .vld(vld_v), .vpn_a(vpn_q), .asid_a(asid_q),
    .req_vpn(req_vpn), .req_asid(req_asid),
    .match_vec(match_vec), .any_match(any_match), .hit_idx(hit_idx)
  );

  tlb_victim #(.N(N)) u_victim (
    .vld(vld_v), .refb(ref_v), .hand(hand_q),
    .fill_idx(fill_idx), .use_clock(use_clock), .clr_mask(clr_mask)
  );

  assign sel = fl_q[hit_idx];
  assign acc = acc_e'(req_acc);

  // R4/R5: rights demanded by the access kind and privilege
  always_comb begin
    unique case (acc)
      ACC_LOAD:  perm_bad = !sel.rd;
      ACC_STORE: perm_bad = !sel.wr;
      ACC_FETCH: perm_bad = !sel.ex;
      default:   perm_bad = 1'b1;
    endcase
    if (sel.kern && req_user) perm_bad = 1'b1;
  end

  assign is_store  = (acc == ACC_STORE);
  assign hit       = req_valid && any_match;
  assign walk_req  = req_valid && !any_match;               // R8
  assign fault     = hit && perm_bad;                       // R7 priority
  assign ok_hit    = hit && !perm_bad;
  assign dirty_req = ok_hit && is_store && !sel.dirty;      // R6
  assign grant     = ok_hit && !(is_store && !sel.dirty);
  assign xl_ppn    = ppn_q[hit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_q   <= '0;
      hand_q <= '0;
    end else if (flush) begin                               // R11
      for (int i = 0; i < N; i++) begin
        fl_q[i].vld  <= 1'b0;
        fl_q[i].refb <= 1'b0;
      end
      hand_q <= '0;
    end else begin
      if (ok_hit) fl_q[hit_idx].refb <= 1'b1;               // R10
      if (dirty_req && dirty_ack) fl_q[hit_idx].dirty <= 1'b1;
      if (refill_valid) begin
        if (use_clock) begin
          for (int i = 0; i < N; i++) begin
            if (clr_mask[i]) fl_q[i].refb <= 1'b0;
          end
          hand_q <= IDX_W'((int'(fill_idx) + 1) % N);
        end
        fl_q[fill_idx] <= '{vld: 1'b1, rd: refill_perm[0], wr: refill_perm[1],
                            ex: refill_perm[2], kern: refill_perm[3],
                            dirty: refill_dirty, refb: 1'b1};
        vpn_q[fill_idx]  <= refill_vpn;
        asid_q[fill_idx] <= refill_asid;
        ppn_q[fill_idx]  <= refill_ppn;
      end
    end
  end
endmodule

// File: rtl/tlb_guard_chk.sv
`timescale 1ns/1ps
module tlb_guard_chk #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [VPN_W-1:0]  req_vpn,
  input logic [1:0]        req_acc,
  input logic              req_user,
  input logic [ASID_W-1:0] req_asid,
  input logic              hit,
  input logic              fault,
  input logic              grant,
  input logic              walk_req,
  input logic              dirty_req,
  input logic              dirty_ack,
  input logic              refill_valid,
  input logic              flush,
  input logic [N-1:0]      match_vec
);
  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);

  a_r2_grant_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (hit && req_valid));

  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  a_r4_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> hit);

  a_r6_dirty_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_req |-> (req_acc == 2'd1 && !grant));

  a_r6_ack_settles: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_req && dirty_ack && !flush && !refill_valid) |=>
      (!(req_valid && hit && $stable(req_vpn) && $stable(req_asid) && $stable(req_user))
       || !dirty_req));

  a_r7_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!grant && !dirty_req));

  a_r8_walk_is_miss: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> (!hit && req_valid));
endmodule

bind tlb_guard tlb_guard_chk #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
  .req_acc(req_acc), .req_user(req_user), .req_asid(req_asid),
  .hit(hit), .fault(fault), .grant(grant), .walk_req(walk_req),
  .dirty_req(dirty_req), .dirty_ack(dirty_ack), .refill_valid(refill_valid),
  .flush(flush), .match_vec(match_vec)
);

// File: tb/test_tlb_guard.sv
`timescale 1ns/1ps
module test_tlb_guard;
  localparam int N = 16, VPN_W = 20, PPN_W = 16, ASID_W = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_user = 0, dirty_ack = 0;
  logic [VPN_W-1:0] req_vpn = '0, refill_vpn = '0;
  logic [1:0] req_acc = '0;
  logic [ASID_W-1:0] req_asid = '0, refill_asid = '0;
  logic hit, fault, grant, walk_req, dirty_req;
  logic [PPN_W-1:0] xl_ppn, refill_ppn = '0;
  logic refill_valid = 0, refill_dirty = 0, flush = 0;
  logic [3:0] refill_perm = '0;

  always #10 clk = ~clk;

  tlb_guard #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) i_tlb_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_acc(req_acc), .req_user(req_user), .req_asid(req_asid),
    .hit(hit), .fault(fault), .grant(grant), .xl_ppn(xl_ppn),
    .walk_req(walk_req), .dirty_req(dirty_req), .dirty_ack(dirty_ack),
    .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_asid(refill_asid),
    .refill_ppn(refill_ppn), .refill_perm(refill_perm), .refill_dirty(refill_dirty),
    .flush(flush)
  );

  typedef struct {
    logic [4:0] flags;   // hit fault grant dirty_req walk_req
    logic [PPN_W-1:0] ppn;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // monitor: pops expected items and compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        logic [4:0] act;
        e = q.pop_front();
        act = {hit, fault, grant, dirty_req, walk_req};
        checks++;
        if (act !== e.flags || (e.flags[4] && xl_ppn !== e.ppn)) begin
          errors++;
          $display("FAIL %s: hit/fault/grant/dreq/walk=%b ppn=%h expected %b ppn=%h",
                   e.tag, act, xl_ppn, e.flags, e.ppn);
        end
      end
    end
  end

  task automatic look(input logic [VPN_W-1:0] vpn, input logic [1:0] acc,
                      input logic user, input logic [ASID_W-1:0] asid,
                      input logic ack, input logic [4:0] exp_f,
                      input logic [PPN_W-1:0] exp_p, input string tag);
    exp_t e;
    @(negedge clk);
    refill_valid = 0; flush = 0;
    req_valid = 1; req_vpn = vpn; req_acc = acc; req_user = user;
    req_asid = asid; dirty_ack = ack;
    e.flags = exp_f; e.ppn = exp_p; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                      input logic [PPN_W-1:0] ppn, input logic [3:0] perm,
                      input logic dty);
    @(negedge clk);
    req_valid = 0; dirty_ack = 0; flush = 0;
    refill_valid = 1; refill_vpn = vpn; refill_asid = asid;
    refill_ppn = ppn; refill_perm = perm; refill_dirty = dty;
    @(negedge clk);
    refill_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    req_valid = 0; dirty_ack = 0; refill_valid = 0; flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  // flag order: hit fault grant dirty_req walk_req
  localparam logic [4:0] F_MISS = 5'b00001, F_OK = 5'b10100, F_FLT = 5'b11000,
                         F_DRQ = 5'b10010;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    look(20'h5, 2'd0, 1, 8'h1, 0, F_MISS, '0, "R1 reset miss");

    fill(20'h5, 8'h1, 16'h00A5, 4'b0011, 0);
    look(20'h5, 2'd0, 1, 8'h1, 0, F_OK, 16'h00A5, "R2 load hit");
    look(20'h5, 2'd0, 1, 8'h2, 0, F_MISS, '0, "R3 foreign asid");
    look(20'h5, 2'd2, 1, 8'h1, 0, F_FLT, 16'h00A5, "R4 fetch no exec");
    look(20'h5, 2'd3, 0, 8'h1, 0, F_FLT, 16'h00A5, "R4 bad kind");
    look(20'h5, 2'd1, 1, 8'h1, 0, F_DRQ, 16'h00A5, "R6 clean store waits");
    look(20'h5, 2'd1, 1, 8'h1, 1, F_DRQ, 16'h00A5, "R6 clean store acked");
    look(20'h5, 2'd1, 1, 8'h1, 0, F_OK, 16'h00A5, "R6 store after dirty");

    fill(20'h7, 8'h1, 16'h0077, 4'b1100, 0);
    look(20'h7, 2'd2, 1, 8'h1, 0, F_FLT, 16'h0077, "R5 user on kernel page");
    look(20'h7, 2'd2, 0, 8'h1, 0, F_OK, 16'h0077, "R5 kernel fetch");
    look(20'h7, 2'd1, 0, 8'h1, 0, F_FLT, 16'h0077, "R7 fault masks dirty");
    look(20'h7, 2'd0, 0, 8'h1, 0, F_FLT, 16'h0077, "R4 load no read");

    look(20'h9, 2'd0, 0, 8'h1, 0, F_MISS, '0, "R8 walk first");
    look(20'h9, 2'd0, 0, 8'h1, 0, F_MISS, '0, "R8 walk held");
    fill(20'h9, 8'h1, 16'h0099, 4'b0001, 1);
    look(20'h9, 2'd0, 0, 8'h1, 0, F_OK, 16'h0099, "R8 hit after refill");

    do_flush();
    look(20'h5, 2'd0, 1, 8'h1, 0, F_MISS, '0, "R11 flushed 5");
    look(20'h9, 2'd0, 0, 8'h1, 0, F_MISS, '0, "R11 flushed 9");

    for (int i = 0; i < N; i++) fill(20'h100 + i, 8'h3, 16'(i), 4'b0111, 1);
    for (int i = 0; i < N; i++)
      look(20'h100 + i, 2'd0, 1, 8'h3, 0, F_OK, 16'(i), "R9 all resident");

    // all refs set, hand at 0: slot 0 replaced, every ref cleared, hand -> 1
    fill(20'h200, 8'h3, 16'h0050, 4'b0111, 1);
    look(20'h101, 2'd0, 1, 8'h3, 0, F_OK, 16'h0001, "R10 touch slot 1");
    // hand at 1 with ref set: cleared, slot 2 replaced
    fill(20'h201, 8'h3, 16'h0051, 4'b0111, 1);
    look(20'h100, 2'd0, 1, 8'h3, 0, F_MISS, '0, "R10 slot0 evicted");
    look(20'h102, 2'd0, 1, 8'h3, 0, F_MISS, '0, "R10 slot2 evicted");
    look(20'h101, 2'd0, 1, 8'h3, 0, F_OK, 16'h0001, "R10 touched kept");
    look(20'h103, 2'd0, 1, 8'h3, 0, F_OK, 16'h0003, "R10 neighbour kept");
    look(20'h200, 2'd0, 1, 8'h3, 0, F_OK, 16'h0050, "R10 first new");
    look(20'h201, 2'd0, 1, 8'h3, 0, F_OK, 16'h0051, "R10 second new");

    @(negedge clk) req_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule